// File: doc/BRIEF.md
# External Interrupt Request Latch

This block turns one active-low external interrupt pin into a latched request for a processor. The pin is resynchronized into the core clock domain, watched for a falling edge (and, if selected, for a low level), and any qualifying event sets a pending latch. The latch is released by an acknowledge, which comes either from the processor's vector-fetch strobe or from software writing a 1 to an acknowledge bit in a small control/status register. Reset also releases it.

A sense-select bit chooses between two behaviours. In edge sensing, only a falling edge sets the latch and an acknowledge releases it at once. In level sensing, a held-low pin keeps the request alive. The latch drops only when an acknowledge has been seen and the pin is back high, and these two can happen in either order. A mask bit blocks the request line to the processor without hiding the pending flag, so polling software can still see it. The block also drives the fixed two-byte vector address that the processor fetches when it takes the interrupt.

Top module: `ext_irq_latch`

## Requirements
- R1: After reset, the register reads 0 (pending, mask and sense-select all clear) and `cpu_irq` is low.
- R2: The pin passes through a SYNC_STAGES-flop synchronizer. A falling edge driven before rising edge k shows as pending after rising edge k+SYNC_STAGES and not earlier.
- R3: With sense-select 0 (edge sensing), holding the pin low after the latch has been released does not set it again. Only a new falling edge does.
- R4: With edge sensing, an acknowledge releases the pending latch at the next rising edge, even while the pin is still low.
- R5: With sense-select 1 (level sensing), the latch stays set for as long as the synchronized pin is low, including after an acknowledge.
- R6: With level sensing, the latch is released only once both an acknowledge has occurred and the pin has returned high. This holds whichever of the two comes first.
- R7: An acknowledge is produced either by a `vec_fetch` pulse or by a register write with bit 2 (ACK) set. Bit 2 always reads 0.
- R8: When a fresh falling edge is detected in the same cycle as an acknowledge, the latch stays set.
- R9: Register bit 1 (mask) forces `cpu_irq` low. Register bit 0 (pending) still shows the latch. With the mask clear, `cpu_irq` follows pending.
- R10: Reset clears both the latch and sense-select (bit 3). If the pin stays low through and after reset, no request appears until a new falling edge.
- R11: `vec_addr_hi` carries VEC_BASE (default 16'hFFFA) and `vec_addr_lo` carries VEC_BASE+1 (default 16'hFFFB).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | Asynchronous active-low interrupt pin |
| vec_fetch | input | 1 | Processor vector-fetch acknowledge strobe, one cycle |
| reg_wr | input | 1 | Write strobe for the control/status register |
| reg_wdata | input | REG_W | Write data: bit 1 mask, bit 2 ACK, bit 3 sense-select |
| reg_rdata | output | REG_W | Read data: bit 0 pending, bit 1 mask, bit 3 sense-select, other bits 0 |
| cpu_irq | output | 1 | Interrupt request to the processor (pending and not masked) |
| vec_addr_hi | output | ADDR_W | Address of the vector high byte |
| vec_addr_lo | output | ADDR_W | Address of the vector low byte |

## Verification
The bench builds the block with SYNC_STAGES=3 instead of the default 2. This checks that the set and release latencies follow the parameter rather than a fixed two-cycle delay. REG_W=8 and the default vector base are kept, so the bit positions and the 16'hFFFA/16'hFFFB pair are checked as stated. Directed sequences cover both release orders in level sensing, an acknowledge in the same cycle as an edge, and reset with the pin held low. A long run of random pin toggles, strobes and register writes then compares every cycle against a bench-side cycle model, which reaches mode switches while a request is pending.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
   // register bit positions (shared by RTL and documentation)
   localparam int unsigned BIT_PEND = 0;
   localparam int unsigned BIT_MASK = 1;
   localparam int unsigned BIT_ACK  = 2;
   localparam int unsigned BIT_MODE = 3;
   localparam int unsigned MIN_REG_W = BIT_MODE + 1;

   typedef enum logic {
      SENSE_EDGE  = 1'b0,
      SENSE_LEVEL = 1'b1
   } sense_e;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("eirq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   // flops reset to 0 so a pin held low through reset yields no edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
   import ext_irq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   pin_s,
   input  sense_e sense,
   input  logic   ack,
   output logic   pending
);
   logic prev_q, latch_q, hold_q;
   logic latch_d, hold_d, fall;

   assign fall = prev_q & ~pin_s;

   always_comb begin
      latch_d = latch_q;
      hold_d  = hold_q;
      if (sense == SENSE_EDGE) begin
         hold_d = 1'b0;
         if (fall)     latch_d = 1'b1;
         else if (ack) latch_d = 1'b0;
      end else begin
         if (fall) begin
            latch_d = 1'b1;            // new edge wins over a same-cycle ack
         end else if (!pin_s) begin
            latch_d = 1'b1;
            if (ack) hold_d = 1'b1;    // remember ack until pin goes high
         end else if (ack || hold_q) begin
            latch_d = 1'b0;
            hold_d  = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         latch_q <= 1'b0;
         hold_q  <= 1'b0;
      end else begin
         prev_q  <= pin_s;
         latch_q <= latch_d;
         hold_q  <= hold_d;
      end
   end

   assign pending = latch_q;

   AST_EDGE_NO_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (sense == SENSE_EDGE) && !fall && !latch_q |=> !latch_q);          // R3
   AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (sense == SENSE_EDGE) && ack && !fall |=> !latch_q);               // R4
   AST_LEVEL_LOW_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (sense == SENSE_LEVEL) && !pin_s |=> latch_q);                     // R5
   AST_LEVEL_CLEAR_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(latch_q) |-> ($past(sense) == SENSE_EDGE) || $past(pin_s));  // R6
   AST_FALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> latch_q);                                                 // R8
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
   import ext_irq_pkg::*;
#(
   parameter int unsigned REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             pending,
   input  logic             ack_hw,
   output sense_e           sense,
   output logic             mask,
   output logic             ack,
   output logic [REG_W-1:0] rdata
);
   generate
      if (REG_W < MIN_REG_W) begin : g_bad_width
         $error("eirq_regs: REG_W too small for the register fields");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense <= SENSE_EDGE;
         mask  <= 1'b0;
      end else if (wr) begin
         sense <= sense_e'(wdata[BIT_MODE]);
         mask  <= wdata[BIT_MASK];
      end
   end

   assign ack = ack_hw | (wr & wdata[BIT_ACK]);

   always_comb begin
      rdata           = '0;
      rdata[BIT_PEND] = pending;
      rdata[BIT_MASK] = mask;
      rdata[BIT_MODE] = sense;
   end
endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
   import ext_irq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned REG_W       = 8,
   parameter int unsigned ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFFA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_pin_n,
   input  logic              vec_fetch,
   input  logic              reg_wr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              cpu_irq,
   output logic [ADDR_W-1:0] vec_addr_hi,
   output logic [ADDR_W-1:0] vec_addr_lo
);
   localparam logic [ADDR_W-1:0] VEC_LO = VEC_BASE + ADDR_W'(1);

   logic   pin_s, ack, pending, mask;
   sense_e sense;

   eirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(irq_pin_n), .q_sync(pin_s));

   eirq_regs #(.REG_W(REG_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
      .pending(pending), .ack_hw(vec_fetch), .sense(sense),
      .mask(mask), .ack(ack), .rdata(reg_rdata));

   eirq_detect u_detect (
      .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .sense(sense),
      .ack(ack), .pending(pending));

   assign cpu_irq     = pending & ~mask;
   assign vec_addr_hi = VEC_BASE;
   assign vec_addr_lo = VEC_LO;

   AST_IRQ_IMPLIES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> reg_rdata[BIT_PEND]);                                  // R9
endmodule

// File: tb/ext_irq_latch_tb.sv
`timescale 1ns/1ps
module ext_irq_latch_tb;
   localparam int SYNC = 3;
   localparam int W    = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         irq_pin_n = 1'b1;
   logic         vec_fetch = 1'b0;
   logic         reg_wr = 1'b0;
   logic [W-1:0] reg_wdata = '0;
   logic [W-1:0] reg_rdata;
   logic         cpu_irq;
   logic [15:0]  vec_addr_hi, vec_addr_lo;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   ext_irq_latch #(.SYNC_STAGES(SYNC), .REG_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .vec_fetch(vec_fetch),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cpu_irq(cpu_irq), .vec_addr_hi(vec_addr_hi), .vec_addr_lo(vec_addr_lo));

   // ---------------- cycle model built from the requirements ----------------
   logic [SYNC-1:0] m_sr;
   logic m_prev, m_latch, m_hold, m_mode, m_mask;

   function automatic logic [W-1:0] model_rdata();
      logic [W-1:0] r = '0;
      r[0] = m_latch; r[1] = m_mask; r[3] = m_mode;
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sr = '0; m_prev = 0; m_latch = 0; m_hold = 0; m_mode = 0; m_mask = 0;
      end else begin
         logic ps, fall, ack, nl, nh;
         ps   = m_sr[SYNC-1];
         fall = m_prev & ~ps;
         ack  = vec_fetch | (reg_wr & reg_wdata[2]);
         nl = m_latch; nh = m_hold;
         if (!m_mode) begin
            nh = 0;
            if (fall) nl = 1; else if (ack) nl = 0;
         end else if (fall) nl = 1;
         else if (!ps) begin nl = 1; if (ack) nh = 1; end
         else if (ack || m_hold) begin nl = 0; nh = 0; end
         m_latch = nl; m_hold = nh; m_prev = ps;
         m_sr = {m_sr[SYNC-2:0], irq_pin_n};
         if (reg_wr) begin m_mode = reg_wdata[3]; m_mask = reg_wdata[1]; end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic write_reg(logic [W-1:0] d);
      reg_wr = 1'b1; reg_wdata = d; tick(); reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic fetch();
      vec_fetch = 1'b1; tick(); vec_fetch = 1'b0;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(200000 * 5.0);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      void'($urandom(32'd20240611));
      tick(3); rst_n = 1'b1; tick();
      chk("R1 rdata after reset", reg_rdata, 0);
      chk("R1 cpu_irq after reset", cpu_irq, 0);
      chk("R11 vector high", vec_addr_hi, 16'hFFFA);
      chk("R11 vector low", vec_addr_lo, 16'hFFFB);

      // edge sensing: latency, set, ack, no re-trigger on low level
      irq_pin_n = 0; tick(SYNC);
      chk("R2 not yet pending", reg_rdata[0], 0);
      tick();
      chk("R2 pending after sync", reg_rdata[0], 1);
      chk("R9 cpu_irq unmasked", cpu_irq, 1);
      fetch();
      chk("R4 fetch clears edge latch", reg_rdata[0], 0);
      tick(5);
      chk("R3 low level ignored in edge mode", reg_rdata[0], 0);
      irq_pin_n = 1; tick(5);

      // software acknowledge
      irq_pin_n = 0; tick(SYNC + 1);
      write_reg(8'h04);
      chk("R7 ACK bit clears latch", reg_rdata[0], 0);
      chk("R7 ACK bit reads 0", reg_rdata[2], 0);
      irq_pin_n = 1; tick(5);

      // set wins over same-cycle acknowledge
      irq_pin_n = 0; tick(SYNC);
      vec_fetch = 1; tick(); vec_fetch = 0;
      chk("R8 edge beats ack", reg_rdata[0], 1);
      fetch();
      chk("R4 later ack clears", reg_rdata[0], 0);
      irq_pin_n = 1; tick(5);

      // masking
      write_reg(8'h02);
      irq_pin_n = 0; tick(SYNC + 1);
      chk("R9 pending visible when masked", reg_rdata, 8'h03);
      chk("R9 cpu_irq masked", cpu_irq, 0);
      write_reg(8'h00);
      chk("R9 cpu_irq after unmask", cpu_irq, 1);
      fetch(); irq_pin_n = 1; tick(5);

      // level sensing: ack first, then pin high
      write_reg(8'h08);
      chk("R6 sense-select readback", reg_rdata, 8'h08);
      irq_pin_n = 0; tick(SYNC + 1);
      chk("R5 level pending", reg_rdata[0], 1);
      fetch(); tick(5);
      chk("R5 held while pin low after ack", reg_rdata[0], 1);
      irq_pin_n = 1; tick(SYNC);
      chk("R6 not cleared before pin seen high", reg_rdata[0], 1);
      tick();
      chk("R6 cleared after ack then high", reg_rdata[0], 0);

      // level sensing: pin high first, then ack
      irq_pin_n = 0; tick(SYNC + 1);
      irq_pin_n = 1; tick(SYNC + 3);
      chk("R6 high without ack stays pending", reg_rdata, 8'h09);
      fetch();
      chk("R6 cleared after high then ack", reg_rdata[0], 0);

      // reset with pin held low
      irq_pin_n = 0; tick(SYNC + 1);
      chk("R5 pending before reset", reg_rdata[0], 1);
      rst_n = 0; tick(); rst_n = 1; tick(SYNC + 4);
      chk("R10 reset clears latch and mode", reg_rdata, 0);
      chk("R10 no request with pin low", cpu_irq, 0);
      irq_pin_n = 1; tick(5);

      // constrained random against the cycle model
      rst_n = 0; tick(2); rst_n = 1;
      for (int c = 0; c < 4000; c++) begin
         if ($urandom_range(7) == 0) irq_pin_n = ~irq_pin_n;
         vec_fetch = ($urandom_range(11) == 0);
         reg_wr    = ($urandom_range(13) == 0);
         reg_wdata = W'($urandom);
         tick();
         chk("R5 R6 R8 random rdata", reg_rdata, model_rdata());
         chk("R9 random cpu_irq", cpu_irq, m_latch & ~m_mask);
      end
      vec_fetch = 0; reg_wr = 0;

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule